// File: doc/BRIEF.md
# Redundant Thread Fetch Pacer

This block paces instruction fetch for a pair of redundant threads that run the same program on one core. The leading thread fetches freely. The trailing thread may fetch only while it is more than a programmable number of instructions behind the leader. Keeping that distance means the leader meets cache misses first and warms the caches for its twin, and the leader's branches are resolved before the trailing thread reaches them.

Each branch the leading thread commits goes into a small first-in first-out queue as a direction bit and a target address. When the trailing thread reaches a branch, it takes the oldest queued outcome instead of asking a predictor. If no outcome is queued yet, trailing fetch is held for that cycle. If the queue is full, the leader's branch commit is held back through a ready signal.

Each cycle the block takes the number of instructions the leader fetched and the number the trailing thread wants. It returns how many the trailing thread may fetch in that cycle. The block keeps the difference between the two threads' totals as a single gap counter.

Top module: `redundant_fetch_pacer`

## Requirements
- R1: After reset the gap is zero and the outcome queue is empty: `trail_fetch_en`=0, `trail_fetch_grant`=0, `trail_br_valid`=0 and `lead_br_ready`=1.
- R2: `trail_fetch_en` is 1 only when the gap is strictly greater than `slack_cfg` and the trailing thread is not stalled on a branch. The gap is the total leading fetches minus the total trailing grants.
- R3: `trail_fetch_grant` is the smallest of three values: `trail_fetch_req`, gap minus `slack_cfg`, and `FETCH_W` (8). As a result, a grant never takes the gap below `slack_cfg`.
- R4: The gap changes at the next clock edge by `lead_fetch_cnt` (values above `FETCH_W` count as `FETCH_W`) minus the grant of the current cycle. The grant is combinational from the gap register.
- R5: When `lead_br_valid` and `lead_br_ready` are both 1 at a clock edge, the taken bit and the target are stored. From the next cycle they are visible when they reach the head of the queue.
- R6: The queue head is presented on `trail_br_valid`, `trail_br_taken` and `trail_br_target`. `trail_br_req` with `trail_br_valid`=1 removes the head at the clock edge. Outcomes come out in commit order.
- R7: When `trail_br_req` is 1 and the queue is empty, `trail_fetch_en`=0 and `trail_fetch_grant`=0, and nothing is removed.
- R8: With `DEPTH` (4) entries held, `lead_br_ready`=0 and `lead_br_valid` is ignored. No entry beyond `DEPTH` is stored.
- R9: In a cycle where the queue is not full, one branch can be enqueued and the head dequeued at the same edge. The occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slack_cfg | input | CNT_W | Required minimum instruction gap |
| lead_fetch_cnt | input | FCW | Instructions fetched by the leading thread this cycle |
| trail_fetch_req | input | FCW | Instructions the trailing thread wants this cycle |
| trail_fetch_en | output | 1 | Trailing thread may fetch |
| trail_fetch_grant | output | FCW | Instructions the trailing thread may fetch this cycle |
| lead_br_valid | input | 1 | Leading thread commits a branch |
| lead_br_taken | input | 1 | Resolved direction of the committed branch |
| lead_br_target | input | ADDR_W | Resolved target of the committed branch |
| lead_br_ready | output | 1 | Queue can accept a branch outcome |
| trail_br_req | input | 1 | Trailing thread reached a branch |
| trail_br_valid | output | 1 | Queue head holds an outcome |
| trail_br_taken | output | 1 | Direction at the queue head |
| trail_br_target | output | ADDR_W | Target at the queue head |

## Verification
The grant, the enable and the queue head are combinational from registered state. Each one therefore reflects inputs driven in the same cycle together with the state left by earlier edges. A leading fetch count or an enqueue takes effect only after the next rising edge. The bench drives inputs just after a falling edge and samples one time unit later, before the rising edge. It advances its reference gap and reference queue only once that edge has passed. Each check therefore compares against the state one register stage behind the stimulus.

// File: rtl/redundant_fetch_pacer.sv
module redundant_fetch_pacer #(
  parameter int CNT_W   = 16,
  parameter int FETCH_W = 8,
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 4,
  localparam int FCW    = $clog2(FETCH_W + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  slack_cfg,
  input  logic [FCW-1:0]    lead_fetch_cnt,
  input  logic [FCW-1:0]    trail_fetch_req,
  output logic              trail_fetch_en,
  output logic [FCW-1:0]    trail_fetch_grant,
  input  logic              lead_br_valid,
  input  logic              lead_br_taken,
  input  logic [ADDR_W-1:0] lead_br_target,
  output logic              lead_br_ready,
  input  logic              trail_br_req,
  output logic              trail_br_valid,
  output logic              trail_br_taken,
  output logic [ADDR_W-1:0] trail_br_target
);
  localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(FETCH_W);
  localparam logic [CNT_W:0]   GAP_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] gap;
  logic [CNT_W-1:0] avail;
  logic [FCW-1:0]   avail_cap, req_cap, lead_cap;
  logic             br_stall;
  logic [CNT_W:0]   gap_sum;

  logic              taken_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q   [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [OCC_W-1:0]  q_count;
  logic              q_empty, q_full, do_enq, do_deq;

  assign q_empty = (q_count == '0);
  assign q_full  = (q_count == OCC_W'(DEPTH));
  assign do_enq  = lead_br_valid && !q_full;
  assign do_deq  = trail_br_req && !q_empty;

  assign avail     = (gap > slack_cfg) ? gap - slack_cfg : '0;
  assign avail_cap = (avail > WIDTH_C) ? FCW'(FETCH_W) : avail[FCW-1:0];
  assign req_cap   = (trail_fetch_req > FCW'(FETCH_W)) ? FCW'(FETCH_W) : trail_fetch_req;
  assign lead_cap  = (lead_fetch_cnt > FCW'(FETCH_W)) ? FCW'(FETCH_W) : lead_fetch_cnt;
  assign br_stall  = trail_br_req && q_empty;

  assign trail_fetch_en    = !br_stall && (avail != '0);
  assign trail_fetch_grant = br_stall ? '0 : ((req_cap < avail_cap) ? req_cap : avail_cap);

  assign gap_sum = {1'b0, gap} + (CNT_W+1)'(lead_cap) - (CNT_W+1)'(trail_fetch_grant);

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else        gap <= (gap_sum > GAP_MAX) ? GAP_MAX[CNT_W-1:0] : gap_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      q_count <= '0;
    end else begin
      if (do_enq) begin
        taken_q[wr_ptr] <= lead_br_taken;
        tgt_q[wr_ptr]   <= lead_br_target;
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (do_deq)
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      q_count <= q_count + OCC_W'(do_enq) - OCC_W'(do_deq);
    end
  end

  assign lead_br_ready   = !q_full;
  assign trail_br_valid  = !q_empty;
  assign trail_br_taken  = q_empty ? 1'b0 : taken_q[rd_ptr];
  assign trail_br_target = q_empty ? '0 : tgt_q[rd_ptr];
endmodule

module redundant_fetch_pacer_chk #(
  parameter int CNT_W   = 16,
  parameter int FETCH_W = 8,
  parameter int DEPTH   = 4,
  parameter int FCW     = 4,
  parameter int OCC_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] slack_cfg,
  input logic [CNT_W-1:0] gap,
  input logic [FCW-1:0]   lead_fetch_cnt,
  input logic [FCW-1:0]   trail_fetch_req,
  input logic [FCW-1:0]   trail_fetch_grant,
  input logic             trail_fetch_en,
  input logic             lead_br_valid,
  input logic             lead_br_ready,
  input logic             trail_br_req,
  input logic             trail_br_valid,
  input logic [OCC_W-1:0] q_count
);
  assert_grant_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(trail_fetch_grant) <= FETCH_W) && (trail_fetch_grant <= trail_fetch_req));

  assert_slack_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_fetch_grant != '0) |-> (int'(gap) - int'(trail_fetch_grant) >= int'(slack_cfg)));

  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trail_fetch_en |-> (gap > slack_cfg));

  assert_gap_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && int'($past(gap)) < (2**CNT_W - 1 - FETCH_W) && int'($past(lead_fetch_cnt)) <= FETCH_W)
    |-> (int'(gap) == int'($past(gap)) + int'($past(lead_fetch_cnt)) - int'($past(trail_fetch_grant))));

  assert_empty_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_br_req && !trail_br_valid) |-> (trail_fetch_grant == '0 && !trail_fetch_en));

  assert_full_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_count) == DEPTH) |-> !lead_br_ready);

  assert_enq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_br_valid && lead_br_ready && !(trail_br_req && trail_br_valid))
    |=> (int'(q_count) == int'($past(q_count)) + 1));

  assert_deq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_br_req && trail_br_valid && !(lead_br_valid && lead_br_ready))
    |=> (int'(q_count) == int'($past(q_count)) - 1));
endmodule

bind redundant_fetch_pacer redundant_fetch_pacer_chk #(
  .CNT_W(CNT_W), .FETCH_W(FETCH_W), .DEPTH(DEPTH), .FCW(FCW), .OCC_W(OCC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .slack_cfg(slack_cfg), .gap(gap),
  .lead_fetch_cnt(lead_fetch_cnt), .trail_fetch_req(trail_fetch_req),
  .trail_fetch_grant(trail_fetch_grant), .trail_fetch_en(trail_fetch_en),
  .lead_br_valid(lead_br_valid), .lead_br_ready(lead_br_ready),
  .trail_br_req(trail_br_req), .trail_br_valid(trail_br_valid), .q_count(q_count)
);

// File: tb/redundant_fetch_pacer_tb_top.sv
module redundant_fetch_pacer_tb_top;
  localparam int CNT_W = 16, FETCH_W = 8, ADDR_W = 32, DEPTH = 4, FCW = 4;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] slack_cfg = '0;
  logic [FCW-1:0] lead_fetch_cnt = '0, trail_fetch_req = '0;
  logic trail_fetch_en;
  logic [FCW-1:0] trail_fetch_grant;
  logic lead_br_valid = 0, lead_br_taken = 0, lead_br_ready;
  logic [ADDR_W-1:0] lead_br_target = '0;
  logic trail_br_req = 0, trail_br_valid, trail_br_taken;
  logic [ADDR_W-1:0] trail_br_target;

  always #5 clk = ~clk;

  redundant_fetch_pacer #(.CNT_W(CNT_W), .FETCH_W(FETCH_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .slack_cfg(slack_cfg),
    .lead_fetch_cnt(lead_fetch_cnt), .trail_fetch_req(trail_fetch_req),
    .trail_fetch_en(trail_fetch_en), .trail_fetch_grant(trail_fetch_grant),
    .lead_br_valid(lead_br_valid), .lead_br_taken(lead_br_taken),
    .lead_br_target(lead_br_target), .lead_br_ready(lead_br_ready),
    .trail_br_req(trail_br_req), .trail_br_valid(trail_br_valid),
    .trail_br_taken(trail_br_taken), .trail_br_target(trail_br_target));

  int checks = 0, fails = 0;
  int mgap = 0;
  int mcount = 0;
  bit mq_taken [$];
  int mq_tgt [$];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive, check combinational results, advance reference model.
  task automatic cycle(input int lc, input int treq, input bit brq,
                       input bit bv, input bit bt, input int btgt, input string tag);
    int avail, exp_g, lcap;
    bit stall, exp_en, exp_deq, exp_enq;
    @(negedge clk);
    lead_fetch_cnt = FCW'(lc); trail_fetch_req = FCW'(treq); trail_br_req = brq;
    lead_br_valid = bv; lead_br_taken = bt; lead_br_target = ADDR_W'(btgt);
    #1;
    stall  = brq && (mcount == 0);
    avail  = (mgap > int'(slack_cfg)) ? mgap - int'(slack_cfg) : 0;
    exp_en = !stall && avail != 0;
    exp_g  = stall ? 0 : ((treq < avail) ? treq : avail);
    if (exp_g > FETCH_W) exp_g = FETCH_W;
    chk(int'(trail_fetch_grant) == exp_g, {tag, " grant"}, int'(trail_fetch_grant), exp_g);
    chk(trail_fetch_en == exp_en, {tag, " enable"}, int'(trail_fetch_en), int'(exp_en));
    chk(lead_br_ready == (mcount < DEPTH), {tag, " ready"}, int'(lead_br_ready), int'(mcount < DEPTH));
    chk(trail_br_valid == (mcount > 0), {tag, " head valid"}, int'(trail_br_valid), int'(mcount > 0));
    if (mcount > 0) begin
      chk(trail_br_taken == mq_taken[0], {tag, " head taken"}, int'(trail_br_taken), int'(mq_taken[0]));
      chk(int'(trail_br_target) == mq_tgt[0], {tag, " head target"}, int'(trail_br_target), mq_tgt[0]);
    end
    exp_deq = brq && mcount > 0;
    exp_enq = bv && mcount < DEPTH;
    @(posedge clk);
    lcap = (lc > FETCH_W) ? FETCH_W : lc;
    mgap = mgap + lcap - exp_g;
    if (exp_deq) begin void'(mq_taken.pop_front()); void'(mq_tgt.pop_front()); mcount--; end
    if (exp_enq) begin mq_taken.push_back(bt); mq_tgt.push_back(btgt); mcount++; end
    #1;
    lead_br_valid = 0; trail_br_req = 0; lead_fetch_cnt = '0; trail_fetch_req = '0;
  endtask

  task automatic t_reset_R1();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    mgap = 0; mcount = 0; mq_taken.delete(); mq_tgt.delete();
    @(negedge clk); #1;
    chk(trail_fetch_en == 0, "R1 enable", int'(trail_fetch_en), 0);
    chk(trail_fetch_grant == 0, "R1 grant", int'(trail_fetch_grant), 0);
    chk(trail_br_valid == 0, "R1 head valid", int'(trail_br_valid), 0);
    chk(lead_br_ready == 1, "R1 ready", int'(lead_br_ready), 1);
  endtask

  task automatic t_slack_R2_R3();
    slack_cfg = 20;
    cycle(8, 8, 0, 0, 0, 0, "R2 gap0");
    cycle(8, 8, 0, 0, 0, 0, "R2 gap8");
    cycle(8, 8, 0, 0, 0, 0, "R2 gap16");
    cycle(0, 8, 0, 0, 0, 0, "R3 partial gap24");
    cycle(0, 8, 0, 0, 0, 0, "R3 floor gap20");
    cycle(8, 15, 0, 0, 0, 0, "R3 clamp");
    cycle(8, 15, 0, 0, 0, 0, "R3 clamp2");
  endtask

  task automatic t_step_R4();
    slack_cfg = 0;
    for (int i = 0; i < 6; i++) cycle(i + 3, 2 * i, 0, 0, 0, 0, "R4 mixed step");
    cycle(15, 0, 0, 0, 0, 0, "R4 lead clamp");
    cycle(0, 8, 0, 0, 0, 0, "R4 after clamp");
  endtask

  task automatic t_queue_R5_R6();
    cycle(8, 0, 0, 1, 1, 'h100, "R5 push a");
    cycle(8, 0, 0, 1, 0, 'h204, "R5 push b");
    cycle(0, 0, 0, 1, 1, 'h3f8, "R5 push c");
    cycle(0, 4, 1, 0, 0, 0, "R6 pop a");
    cycle(0, 4, 1, 0, 0, 0, "R6 pop b");
    cycle(0, 4, 1, 0, 0, 0, "R6 pop c");
  endtask

  task automatic t_empty_R7();
    cycle(8, 8, 1, 0, 0, 0, "R7 stall empty");
    cycle(0, 8, 1, 1, 0, 'h77c, "R7 stall while pushing");
    cycle(0, 8, 1, 0, 0, 0, "R7 resume");
  endtask

  task automatic t_full_R8();
    for (int i = 0; i < DEPTH + 2; i++) cycle(0, 0, 0, 1, i[0], 'h1000 + 4 * i, "R8 fill");
    for (int i = 0; i < DEPTH + 1; i++) cycle(0, 0, 1, 0, 0, 0, "R8 drain");
  endtask

  task automatic t_both_R9();
    cycle(0, 0, 0, 1, 1, 'h500, "R9 prime");
    cycle(0, 0, 1, 1, 0, 'h504, "R9 enq+deq");
    cycle(0, 0, 1, 1, 1, 'h508, "R9 enq+deq2");
    cycle(0, 0, 1, 0, 0, 0, "R9 drain");
    cycle(0, 0, 0, 0, 0, 0, "R9 empty");
  endtask

  initial begin
    t_reset_R1();
    t_slack_R2_R3();
    t_step_R4();
    t_queue_R5_R6();
    t_empty_R7();
    t_full_R8();
    t_both_R9();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule